// File: doc/BRIEF.md
# Side-Effect Write Register Field

This block holds one software-visible field in flops inside a wider control/status word. Software reaches the same field through a primary address and through one or more alias addresses. Each address has its own write strobe and read strobe. All addresses share one set of byte enables and one write data bus. A 3-bit mode input selects how a software write changes the stored bits. The choices are a plain overwrite, five bitwise rules that combine the old value with the write data, and two forcing rules that ignore the data.

A write changes a field bit only when the byte enable of the lane holding that bit is set. The block merges the strobes of every address into one any-write and one any-read indication. From these it drives a software-modified pulse and a software-accessed pulse. During a read it returns the field at its fixed bit position and returns zero in every other bit. The stored value is always presented to hardware on a dedicated output.

Top module: `sidefx_field_reg`

## Requirements
- R1: While reset is asserted, and after reset until the first enabled write, `field_q` equals the parameter RESET_VAL (0xA5C3 by default).
- R2: With `mode` = 0 (plain), an enabled write replaces each enabled field bit with the matching write data bit.
- R3: With `mode` = 1, each enabled field bit becomes old OR data. A bit is never cleared in this mode.
- R4: With `mode` = 2, each enabled field bit becomes old AND NOT data. A bit is never set in this mode.
- R5: With `mode` = 3, each enabled field bit becomes old XOR data. With `mode` = 4 it becomes old XNOR data.
- R6: With `mode` = 5, each enabled field bit becomes old AND data.
- R7: With `mode` = 6, every enabled field bit becomes 0. With `mode` = 7, every enabled field bit becomes 1. The write data is ignored in both modes.
- R8: Byte lane i covers bus bits 8i+7..8i. The field occupies bus bits FIELD_LSB+FIELD_W-1..FIELD_LSB (19..4 by default). A field bit whose lane enable is low keeps its value across a write.
- R9: A write or read strobe on any address, primary (index 0) or alias (index 1 and up), acts on the field identically.
- R10: `sw_mod` is high in the same cycle as a write strobe on any address when at least one byte enable covering the field is set. It is low otherwise, including for writes that enable only lanes outside the field.
- R11: `sw_acc` is high in the same cycle as any read strobe, or any write strobe with a covering byte enable, on any address. It is low otherwise.
- R12: While any read strobe is high, `rd_data` carries the stored field at bits FIELD_LSB+FIELD_W-1..FIELD_LSB and zero elsewhere. With no read strobe, `rd_data` is all zero.
- R13: A field bit changes only on a clock edge where a write strobe and that bit's lane enable were both high. Stored values appear on `field_q` one cycle after the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_stb | input | NUM_ADDR (2) | Write strobe per address, index 0 is the primary address |
| rd_stb | input | NUM_ADDR (2) | Read strobe per address |
| byte_en | input | DATA_W/8 (4) | Byte lane enables for writes |
| wr_data | input | DATA_W (32) | Write data |
| mode | input | 3 | Write-modify rule, encoded as listed in R2 to R7 |
| field_q | output | FIELD_W (16) | Stored field value presented to hardware |
| sw_mod | output | 1 | Software-modified pulse, merged over all addresses |
| sw_acc | output | 1 | Software-accessed pulse, merged over all addresses |
| rd_data | output | DATA_W (32) | Read data with the field in place and other bits zero |

## Verification
The embedded assertions check properties that must hold every cycle. Lanes whose enable was low keep their bits. Nothing changes without a write. The set rule never clears a bit and the clear rule never sets one. A modified pulse always comes with a write strobe. A read strobe always raises the accessed pulse, and the read bus is zero when idle. The exact value each mode produces from a given old value, data pattern and lane mask can only be shown by the bench. The bench computes those values with its own model, on directed and random traffic through both the primary and the alias address. The bench alone also shows the reset value and that writes through an alias have the same effect as writes through the primary address.

// File: rtl/sidefx_field_pkg.sv
package sidefx_field_pkg;

   typedef enum logic [2:0] {
      WM_PLAIN        = 3'd0,
      WM_ONE_SETS     = 3'd1,
      WM_ONE_CLEARS   = 3'd2,
      WM_ONE_TOGGLES  = 3'd3,
      WM_ZERO_TOGGLES = 3'd4,
      WM_ZERO_CLEARS  = 3'd5,
      WM_FORCE_ZERO   = 3'd6,
      WM_FORCE_ONE    = 3'd7
   } wmode_e;

   // Next value of one stored bit under a given rule
   function automatic logic next_bit(input wmode_e m, input logic old_b, input logic d_b);
      logic r;
      case (m)
         WM_PLAIN:        r = d_b;
         WM_ONE_SETS:     r = old_b | d_b;
         WM_ONE_CLEARS:   r = old_b & ~d_b;
         WM_ONE_TOGGLES:  r = old_b ^ d_b;
         WM_ZERO_TOGGLES: r = old_b ~^ d_b;
         WM_ZERO_CLEARS:  r = old_b & d_b;
         WM_FORCE_ZERO:   r = 1'b0;
         WM_FORCE_ONE:    r = 1'b1;
         default:         r = old_b;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/sfr_alias_merge.sv
module sfr_alias_merge #(
   parameter int unsigned NUM_ADDR  = 2,
   parameter int unsigned LANES     = 4,
   parameter int unsigned FIELD_LSB = 4,
   parameter int unsigned FIELD_W   = 16
) (
   input  logic [NUM_ADDR-1:0] wr_stb,
   input  logic [NUM_ADDR-1:0] rd_stb,
   input  logic [LANES-1:0]    byte_en,
   output logic                any_wr,
   output logic                any_rd,
   output logic                sw_mod,
   output logic                sw_acc
);

   localparam int unsigned FIELD_MSB = FIELD_LSB + FIELD_W - 1;

   logic [LANES-1:0] lane_cover;
   logic             lane_hit;

   for (genvar l = 0; l < LANES; l++) begin : g_cover
      localparam int unsigned LO = l * 8;
      localparam int unsigned HI = l * 8 + 7;
      if (HI >= FIELD_LSB && LO <= FIELD_MSB) begin : g_in
         assign lane_cover[l] = 1'b1;
      end else begin : g_out
         assign lane_cover[l] = 1'b0;
      end
   end

   assign any_wr   = |wr_stb;
   assign any_rd   = |rd_stb;
   assign lane_hit = |(byte_en & lane_cover);
   assign sw_mod   = any_wr & lane_hit;
   assign sw_acc   = any_rd | (any_wr & lane_hit);

endmodule

// File: rtl/sfr_field_update.sv
module sfr_field_update
   import sidefx_field_pkg::*;
#(
   parameter int unsigned              DATA_W    = 32,
   parameter int unsigned              FIELD_LSB = 4,
   parameter int unsigned              FIELD_W   = 16,
   parameter logic [FIELD_W-1:0]       RESET_VAL = 'hA5C3,
   localparam int unsigned             LANES     = DATA_W / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                any_wr,
   input  logic [LANES-1:0]    byte_en,
   input  logic [FIELD_W-1:0]  fdata,
   input  wmode_e              mode,
   output logic [FIELD_W-1:0]  q
);

   logic [FIELD_W-1:0] bit_en;
   logic [FIELD_W-1:0] rule_q;
   logic [FIELD_W-1:0] next_q;

   for (genvar j = 0; j < FIELD_W; j++) begin : g_bit
      localparam int unsigned LANE = (FIELD_LSB + j) / 8;
      assign bit_en[j] = byte_en[LANE];
      assign rule_q[j] = next_bit(mode, q[j], fdata[j]);
   end

   always_comb begin
      next_q = q;
      if (any_wr) begin
         next_q = (rule_q & bit_en) | (q & ~bit_en);
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         q <= RESET_VAL;
      end else begin
         q <= next_q;
      end
   end

   a_r13_hold_without_write: assert property (@(posedge clk) disable iff (!rst_n)
      !any_wr |=> $stable(q));

   a_r8_disabled_lanes_held: assert property (@(posedge clk) disable iff (!rst_n)
      any_wr |=> ((q ^ $past(q)) & ~$past(bit_en)) == '0);

   a_r3_set_never_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (any_wr && mode == WM_ONE_SETS) |=> (q & $past(q)) == $past(q));

   a_r4_clear_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
      (any_wr && mode == WM_ONE_CLEARS) |=> (q | $past(q)) == $past(q));

endmodule

// File: rtl/sfr_readback.sv
module sfr_readback #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned FIELD_LSB = 4,
   parameter int unsigned FIELD_W   = 16
) (
   input  logic                any_rd,
   input  logic [FIELD_W-1:0]  q,
   output logic [DATA_W-1:0]   rd_data
);

   always_comb begin
      rd_data = '0;
      if (any_rd) begin
         rd_data[FIELD_LSB +: FIELD_W] = q;
      end
   end

endmodule

// File: rtl/sidefx_field_reg.sv
module sidefx_field_reg
   import sidefx_field_pkg::*;
#(
   parameter int unsigned        DATA_W    = 32,
   parameter int unsigned        NUM_ADDR  = 2,
   parameter int unsigned        FIELD_LSB = 4,
   parameter int unsigned        FIELD_W   = 16,
   parameter logic [FIELD_W-1:0] RESET_VAL = 'hA5C3,
   localparam int unsigned       LANES     = DATA_W / 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_ADDR-1:0] wr_stb,
   input  logic [NUM_ADDR-1:0] rd_stb,
   input  logic [LANES-1:0]    byte_en,
   input  logic [DATA_W-1:0]   wr_data,
   input  logic [2:0]          mode,
   output logic [FIELD_W-1:0]  field_q,
   output logic                sw_mod,
   output logic                sw_acc,
   output logic [DATA_W-1:0]   rd_data
);

   if (DATA_W % 8 != 0 || DATA_W == 0) begin : g_bad_width
      $error("DATA_W must be a nonzero multiple of 8");
   end
   if (FIELD_W == 0 || FIELD_LSB + FIELD_W > DATA_W) begin : g_bad_field
      $error("field must be nonempty and fit inside the data word");
   end
   if (NUM_ADDR < 1) begin : g_bad_addr
      $error("at least the primary address is required");
   end

   logic any_wr;
   logic any_rd;
   logic unused_data_bits;

   assign unused_data_bits = ^wr_data;

   sfr_alias_merge #(
      .NUM_ADDR (NUM_ADDR),
      .LANES    (LANES),
      .FIELD_LSB(FIELD_LSB),
      .FIELD_W  (FIELD_W)
   ) u_merge (
      .wr_stb (wr_stb),
      .rd_stb (rd_stb),
      .byte_en(byte_en),
      .any_wr (any_wr),
      .any_rd (any_rd),
      .sw_mod (sw_mod),
      .sw_acc (sw_acc)
   );

   sfr_field_update #(
      .DATA_W   (DATA_W),
      .FIELD_LSB(FIELD_LSB),
      .FIELD_W  (FIELD_W),
      .RESET_VAL(RESET_VAL)
   ) u_update (
      .clk    (clk),
      .rst_n  (rst_n),
      .any_wr (any_wr),
      .byte_en(byte_en),
      .fdata  (wr_data[FIELD_LSB +: FIELD_W]),
      .mode   (wmode_e'(mode)),
      .q      (field_q)
   );

   sfr_readback #(
      .DATA_W   (DATA_W),
      .FIELD_LSB(FIELD_LSB),
      .FIELD_W  (FIELD_W)
   ) u_read (
      .any_rd (any_rd),
      .q      (field_q),
      .rd_data(rd_data)
   );

   a_r10_mod_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      sw_mod |-> (|wr_stb));

   a_r11_read_is_access: assert property (@(posedge clk) disable iff (!rst_n)
      (|rd_stb) |-> sw_acc);

   a_r12_idle_bus_zero: assert property (@(posedge clk) disable iff (!rst_n)
      !(|rd_stb) |-> rd_data == '0);

   a_r11_access_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      sw_acc |-> ((|rd_stb) || (|wr_stb)));

endmodule

// File: tb/sidefx_field_reg_bench.sv
`timescale 1ns/1ps
module sidefx_field_reg_bench;

   localparam int DATA_W    = 32;
   localparam int NUM_ADDR  = 2;
   localparam int FIELD_LSB = 4;
   localparam int FIELD_W   = 16;
   localparam int LANES     = DATA_W / 8;
   localparam logic [15:0] RST_V = 16'hA5C3;

   logic                clk = 1'b0;
   logic                rst_n;
   logic [NUM_ADDR-1:0] wr_stb;
   logic [NUM_ADDR-1:0] rd_stb;
   logic [LANES-1:0]    byte_en;
   logic [DATA_W-1:0]   wr_data;
   logic [2:0]          mode;
   logic [FIELD_W-1:0]  field_q;
   logic                sw_mod;
   logic                sw_acc;
   logic [DATA_W-1:0]   rd_data;

   int checks = 0;
   int errors = 0;
   bit done   = 0;
   logic [FIELD_W-1:0] model;

   always #2.5 clk = ~clk;

   sidefx_field_reg u_sidefx_field_reg (
      .clk(clk), .rst_n(rst_n), .wr_stb(wr_stb), .rd_stb(rd_stb),
      .byte_en(byte_en), .wr_data(wr_data), .mode(mode),
      .field_q(field_q), .sw_mod(sw_mod), .sw_acc(sw_acc), .rd_data(rd_data)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic logic [LANES-1:0] cover_mask();
      logic [LANES-1:0] m = '0;
      for (int b = FIELD_LSB; b < FIELD_LSB + FIELD_W; b++) m[b/8] = 1'b1;
      return m;
   endfunction

   // Reference rule set, written from the requirements
   function automatic logic [FIELD_W-1:0] ref_next(input logic [FIELD_W-1:0] old,
         input logic [2:0] m, input logic [LANES-1:0] be, input logic [DATA_W-1:0] d);
      logic [FIELD_W-1:0] r = old;
      for (int j = 0; j < FIELD_W; j++) begin
         logic o, x;
         o = old[j];
         x = d[FIELD_LSB + j];
         if (be[(FIELD_LSB + j) / 8]) begin
            case (m)
               3'd0: r[j] = x;
               3'd1: r[j] = o | x;
               3'd2: r[j] = o & ~x;
               3'd3: r[j] = o ^ x;
               3'd4: r[j] = ~(o ^ x);
               3'd5: r[j] = o & x;
               3'd6: r[j] = 1'b0;
               default: r[j] = 1'b1;
            endcase
         end
      end
      return r;
   endfunction

   task automatic do_write(input string req, input int addr, input logic [2:0] m,
         input logic [LANES-1:0] be, input logic [DATA_W-1:0] d);
      logic hit;
      @(negedge clk);
      wr_stb = '0; wr_stb[addr] = 1'b1;
      mode = m; byte_en = be; wr_data = d;
      hit = |(be & cover_mask());
      #1;
      check({req, " R10 sw_mod"}, 32'(sw_mod), 32'(hit));
      check({req, " R11 sw_acc"}, 32'(sw_acc), 32'(hit));
      @(negedge clk);
      wr_stb = '0; byte_en = '0; wr_data = '0;
      model = ref_next(model, m, be, d);
      #1;
      check({req, " R13 field_q"}, 32'(field_q), 32'(model));
   endtask

   task automatic do_read(input string req, input int addr);
      @(negedge clk);
      rd_stb = '0; rd_stb[addr] = 1'b1;
      #1;
      check({req, " R12 rd_data"}, rd_data, 32'(model) << FIELD_LSB);
      check({req, " R11 sw_acc"}, 32'(sw_acc), 32'd1);
      check({req, " R10 sw_mod"}, 32'(sw_mod), 32'd0);
      @(negedge clk);
      rd_stb = '0;
      #1;
      check({req, " R12 idle"}, rd_data, 32'd0);
      check({req, " R11 idle"}, 32'(sw_acc), 32'd0);
   endtask

   task automatic t_reset();
      rst_n = 1'b0; wr_stb = '0; rd_stb = '0; byte_en = '0; wr_data = '0; mode = '0;
      repeat (3) @(negedge clk);
      check("R1 in reset", 32'(field_q), 32'(RST_V));
      rst_n = 1'b1;
      model = RST_V;
      @(negedge clk); #1;
      check("R1 after reset", 32'(field_q), 32'(RST_V));
      do_read("R1 R12 reset read", 0);
   endtask

   task automatic t_plain();
      do_write("R2 plain", 0, 3'd0, 4'hF, 32'hFFF1_2340);
      do_write("R2 plain partial", 1, 3'd0, 4'h2, 32'h0000_ABCD);
      do_read("R2 readback", 0);
   endtask

   task automatic t_set_clear();
      do_write("R7 clear all", 0, 3'd6, 4'hF, 32'hFFFF_FFFF);
      do_write("R3 set on one", 0, 3'd1, 4'hF, 32'h0000_5A50);
      do_write("R3 set again", 1, 3'd1, 4'hF, 32'h0000_0F00);
      do_write("R4 clear on one", 0, 3'd2, 4'hF, 32'h0000_0A50);
      do_read("R4 readback", 1);
   endtask

   task automatic t_toggles();
      do_write("R5 toggle one", 0, 3'd3, 4'hF, 32'h000F_F0F0);
      do_write("R5 toggle zero", 1, 3'd4, 4'hF, 32'h0003_3330);
      do_write("R6 and", 0, 3'd5, 4'hF, 32'h000C_CC00);
      do_write("R7 set all", 1, 3'd7, 4'hF, 32'h0000_0000);
      do_write("R6 and after set", 0, 3'd5, 4'hF, 32'h0006_9690);
   endtask

   task automatic t_lanes();
      do_write("R7 set all", 0, 3'd7, 4'hF, '0);
      do_write("R8 lane0 only clear", 0, 3'd6, 4'h1, '0);
      do_write("R8 lane2 only plain", 1, 3'd0, 4'h4, 32'h0000_0000);
      do_write("R8 R10 outside lane", 0, 3'd6, 4'h8, '0);
      do_write("R8 no lanes", 1, 3'd6, 4'h0, '0);
      do_read("R8 readback", 0);
   endtask

   task automatic t_alias();
      do_write("R9 primary plain", 0, 3'd0, 4'hF, 32'h0001_2340);
      do_write("R9 alias toggle", 1, 3'd3, 4'hF, 32'h0001_2340);
      do_write("R9 alias plain", 1, 3'd0, 4'hF, 32'h000B_EEF0);
      do_read("R9 alias read", 1);
      do_read("R9 primary read", 0);
   endtask

   task automatic t_random();
      for (int k = 0; k < 80; k++) begin
         logic [2:0] m;
         logic [LANES-1:0] be;
         logic [DATA_W-1:0] d;
         int a;
         m = 3'($urandom_range(0, 7));
         be = LANES'($urandom);
         d = $urandom;
         a = $urandom_range(0, NUM_ADDR - 1);
         do_write("R9 random", a, m, be, d);
         if (k % 8 == 0) do_read("R12 random read", a);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 5);
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   initial begin
      t_reset();
      t_plain();
      t_set_clear();
      t_toggles();
      t_lanes();
      t_alias();
      t_random();
      finish_run();
   end

endmodule